// File: doc/BRIEF.md
# Six-Pin GPIO Port with Address Takeover

This block is a six-pin general-purpose I/O port behind a byte-wide register bus. Software writes a direction register, an output data register, a pull-up enable register and an open-drain enable register. It reads the live pin levels through a separate read-only register. Each pin slice drives an output value, an output enable, a pull-up enable and an open-drain enable toward its pad.

Some operating modes lend the upper pins to the external address bus. When the mode is one of 4, 5 or 6, an address-enable field of n hands the top min(n,6) pins to the address outputs, counting down from bit 5. This happens whatever their direction bits hold. Hardware standby wipes the direction register. Software standby leaves it intact. During software standby, a standby output-enable control decides whether the borrowed address pins keep driving their last value or float.

Top module: `gpio6_port`

## Requirements
- R1: A read with select 0 (direction register) always returns 8'hFF, whatever has been written.
- R2: Only direction bits 5..0 exist. An unclaimed pin whose direction bit is 1 drives its output data bit with output enable high (open-drain bit clear). A pin whose direction bit is 0 has output enable low.
- R3: An active-low asynchronous reset clears the direction, data, pull-up and open-drain registers, so every pin output enable is low after reset.
- R4: While hw_stby is high, the direction register is forced to zero and writes to it are ignored. Data, pull-up and open-drain contents are kept.
- R5: Software standby does not alter the direction register or the behaviour of unclaimed pins.
- R6: In modes 4 to 6 with sw_stby low, address-enable value n claims pins 5 down to 6-n (values 7..15 claim all six). A claimed pin has output enable high and drives the matching addr_out bit.
- R7: In modes 0..3 and 7, no pin is claimed, whatever the address-enable value.
- R8: During software standby with oe_stby high, claimed pins keep output enable high and drive the addr_out value sampled on the last clock before standby began.
- R9: During software standby with oe_stby low, claimed pins have output enable low.
- R10: pin_pu is high only for a pin whose pull-up bit is set, whose direction bit is 0 and that is not claimed.
- R11: An unclaimed output pin with its open-drain bit set drives low for a data 0 and releases the pin (output enable low) for a data 1. pin_od reports the open-drain bit for unclaimed pins and 0 for claimed pins.
- R12: Select codes are 0 direction, 1 data, 2 pin levels (read-only, returns pin_in), 3 pull-up, 4 open-drain. Bits 7..6 read as 0 for codes 1..4. Codes 5..7 read as 0. Writes to codes 2 and 5..7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby level |
| sw_stby | input | 1 | Software standby level |
| oe_stby | input | 1 | Address pins keep driving during software standby |
| mode | input | 3 | Operating mode |
| addr_en | input | 4 | Number of upper pins lent to the address bus |
| addr_out | input | 6 | Address bits for claimed pins |
| wr_en | input | 1 | Single-cycle write strobe |
| sel | input | 3 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| pin_in | input | 6 | Sampled pad levels |
| pin_out | output | 6 | Per-pin output value |
| pin_oe | output | 6 | Per-pin output enable |
| pin_pu | output | 6 | Per-pin pull-up enable |
| pin_od | output | 6 | Per-pin open-drain enable |

## Verification
Two events can fall in the same cycle: a hardware standby pulse and a write to the direction register. The bench raises hw_stby in the very cycle that carries a direction write of all ones. It then requires every unclaimed output enable to be low while the other registers read back unchanged. A second collision sets a pin's direction bit and lets the address-enable field claim that same pin. The port outputs must then show the address bit with enable high, and no pull-up or open-drain on that pin.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
   localparam int SEL_W = 3;
   typedef enum logic [SEL_W-1:0] {
      SEL_DIR  = 3'd0,
      SEL_DATA = 3'd1,
      SEL_PINS = 3'd2,
      SEL_PULL = 3'd3,
      SEL_ODRN = 3'd4
   } gpio_sel_e;
endpackage

// File: rtl/gpio6_regs.sv
module gpio6_regs import gpio6_pkg::*; #(
   parameter int PIN_W  = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  dir_q,
   output logic [PIN_W-1:0]  dat_q,
   output logic [PIN_W-1:0]  pull_q,
   output logic [PIN_W-1:0]  odrn_q,
   output logic [DATA_W-1:0] rdata
);
   localparam int PAD_W = DATA_W - PIN_W;

   logic [PIN_W-1:0] wbits;
   logic             unused_wdata;
   assign wbits        = wdata[PIN_W-1:0];
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         dat_q  <= '0;
         pull_q <= '0;
         odrn_q <= '0;
      end else begin
         if (hw_stby)
            dir_q <= '0;
         else if (wr_en && sel == SEL_DIR)
            dir_q <= wbits;
         if (wr_en && sel == SEL_DATA) dat_q  <= wbits;
         if (wr_en && sel == SEL_PULL) pull_q <= wbits;
         if (wr_en && sel == SEL_ODRN) odrn_q <= wbits;
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         always_comb begin
            unique case (sel)
               SEL_DIR:  rdata = '1;
               SEL_DATA: rdata = {{PAD_W{1'b0}}, dat_q};
               SEL_PINS: rdata = {{PAD_W{1'b0}}, pin_in};
               SEL_PULL: rdata = {{PAD_W{1'b0}}, pull_q};
               SEL_ODRN: rdata = {{PAD_W{1'b0}}, odrn_q};
               default:  rdata = '0;
            endcase
         end
      end else begin : g_nopad
         always_comb begin
            unique case (sel)
               SEL_DIR:  rdata = '1;
               SEL_DATA: rdata = dat_q;
               SEL_PINS: rdata = pin_in;
               SEL_PULL: rdata = pull_q;
               SEL_ODRN: rdata = odrn_q;
               default:  rdata = '0;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/gpio6_claim.sv
module gpio6_claim #(
   parameter int PIN_W   = 6,
   parameter int AEN_W   = 4,
   parameter int MODE_W  = 3,
   parameter int MODE_LO = 4,
   parameter int MODE_HI = 6
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [AEN_W-1:0]  addr_en,
   output logic [PIN_W-1:0]  claim
);
   logic addr_mode;
   int   n_eff;

   assign addr_mode = (int'(mode) >= MODE_LO) && (int'(mode) <= MODE_HI);
   assign n_eff     = (int'(addr_en) > PIN_W) ? PIN_W : int'(addr_en);

   for (genvar i = 0; i < PIN_W; i++) begin : g_bit
      assign claim[i] = addr_mode && ((i + n_eff) >= PIN_W);
   end
endmodule

// File: rtl/gpio6_pin.sv
module gpio6_pin (
   input  logic clk,
   input  logic rst_n,
   input  logic dir,
   input  logic dat,
   input  logic pull,
   input  logic odrn,
   input  logic claim,
   input  logic addr_bit,
   input  logic sw_stby,
   input  logic oe_stby,
   output logic out,
   output logic oe,
   output logic pu_en,
   output logic od_en
);
   logic hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= 1'b0;
      else if (!sw_stby)
         hold_q <= addr_bit;
   end

   always_comb begin
      if (claim) begin
         out   = sw_stby ? hold_q : addr_bit;
         oe    = !sw_stby || oe_stby;
         pu_en = 1'b0;
         od_en = 1'b0;
      end else begin
         out   = dat;
         oe    = dir && !(odrn && dat);
         pu_en = pull && !dir;
         od_en = odrn;
      end
   end
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port import gpio6_pkg::*; #(
   parameter int PIN_W   = 6,
   parameter int DATA_W  = 8,
   parameter int AEN_W   = 4,
   parameter int MODE_W  = 3,
   parameter int MODE_LO = 4,
   parameter int MODE_HI = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby,
   input  logic              sw_stby,
   input  logic              oe_stby,
   input  logic [MODE_W-1:0] mode,
   input  logic [AEN_W-1:0]  addr_en,
   input  logic [PIN_W-1:0]  addr_out,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe,
   output logic [PIN_W-1:0]  pin_pu,
   output logic [PIN_W-1:0]  pin_od
);
   if (PIN_W < 1 || PIN_W > DATA_W) begin : g_bad_width
      $error("gpio6_port: PIN_W must lie in 1..DATA_W");
   end
   if (MODE_LO > MODE_HI || MODE_HI >= (1 << MODE_W)) begin : g_bad_mode
      $error("gpio6_port: address mode window out of range");
   end

   logic [PIN_W-1:0] dir_q, dat_q, pull_q, odrn_q, claim_w;

   gpio6_regs #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .wr_en(wr_en),
      .sel(sel), .wdata(wdata), .pin_in(pin_in),
      .dir_q(dir_q), .dat_q(dat_q), .pull_q(pull_q), .odrn_q(odrn_q),
      .rdata(rdata)
   );

   gpio6_claim #(.PIN_W(PIN_W), .AEN_W(AEN_W), .MODE_W(MODE_W),
                 .MODE_LO(MODE_LO), .MODE_HI(MODE_HI)) u_claim (
      .mode(mode), .addr_en(addr_en), .claim(claim_w)
   );

   for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      gpio6_pin u_pin (
         .clk(clk), .rst_n(rst_n),
         .dir(dir_q[i]), .dat(dat_q[i]), .pull(pull_q[i]), .odrn(odrn_q[i]),
         .claim(claim_w[i]), .addr_bit(addr_out[i]),
         .sw_stby(sw_stby), .oe_stby(oe_stby),
         .out(pin_out[i]), .oe(pin_oe[i]), .pu_en(pin_pu[i]), .od_en(pin_od[i])
      );
   end
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk #(
   parameter int PIN_W  = 6,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hw_stby,
   input logic              sw_stby,
   input logic              oe_stby,
   input logic [2:0]        sel,
   input logic [DATA_W-1:0] rdata,
   input logic [PIN_W-1:0]  addr_out,
   input logic [PIN_W-1:0]  claim,
   input logic [PIN_W-1:0]  pin_out,
   input logic [PIN_W-1:0]  pin_oe,
   input logic [PIN_W-1:0]  pin_pu
);
   // R1
   dir_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel == 3'd0 |-> rdata == {DATA_W{1'b1}});

   // R4
   hw_stby_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stby |=> (pin_oe & ~claim) == '0);

   // R6
   claim_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_stby |-> ((pin_oe & claim) == claim) && (((pin_out ^ addr_out) & claim) == '0));

   // R8
   stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_stby && oe_stby && $past(sw_stby) && claim == $past(claim))
         |-> ((pin_out ^ $past(pin_out)) & claim) == '0);

   // R9
   stby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_stby && !oe_stby) |-> (pin_oe & claim) == '0);

   // R10
   pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_pu & pin_oe) | (pin_pu & claim)) == '0);
endmodule

bind gpio6_port gpio6_port_chk #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
   .oe_stby(oe_stby), .sel(sel), .rdata(rdata), .addr_out(addr_out),
   .claim(claim_w), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
);

// File: tb/gpio6_port_bench.sv
module gpio6_port_bench;
   logic       clk = 1'b0;
   logic       rst_n, hw_stby, sw_stby, oe_stby, wr_en;
   logic [2:0] mode, sel;
   logic [3:0] addr_en;
   logic [5:0] addr_out, pin_in, pin_out, pin_oe, pin_pu, pin_od;
   logic [7:0] wdata, rdata;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio6_port u_gpio6_port (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
      .oe_stby(oe_stby), .mode(mode), .addr_en(addr_en), .addr_out(addr_out),
      .wr_en(wr_en), .sel(sel), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_od(pin_od)
   );

   typedef struct packed {
      logic [2:0] mode;
      logic [3:0] aen;
      logic [5:0] addr, oe, out, pu;
   } vec_t;

   // registers during the walk: dir=0F data=2A pull=3F odrn=00
   localparam vec_t VEC [8] = '{
      '{3'd2, 4'd3, 6'h15, 6'h0F, 6'h0A, 6'h30},  // R7
      '{3'd4, 4'd0, 6'h15, 6'h0F, 6'h0A, 6'h30},  // R6 n=0
      '{3'd4, 4'd2, 6'h15, 6'h3F, 6'h1A, 6'h00},  // R6
      '{3'd5, 4'd4, 6'h33, 6'h3F, 6'h32, 6'h00},  // R6
      '{3'd6, 4'd6, 6'h0C, 6'h3F, 6'h0C, 6'h00},  // R6
      '{3'd6, 4'd9, 6'h21, 6'h3F, 6'h21, 6'h00},  // R6 saturate
      '{3'd7, 4'd6, 6'h21, 6'h0F, 6'h0A, 6'h30},  // R7
      '{3'd4, 4'd1, 6'h00, 6'h2F, 6'h0A, 6'h10}   // R10
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; sel = s; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input string req, input logic [2:0] s, input logic [7:0] exp);
      @(negedge clk);
      sel = s;
      #1 chk(req, rdata, exp);
   endtask

   initial begin
      #(5ns * 20000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; hw_stby = 0; sw_stby = 0; oe_stby = 0; wr_en = 0;
      mode = 3'd2; sel = 3'd1; addr_en = 0; addr_out = 0; wdata = 0; pin_in = 6'h15;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 chk("R3 oe", {2'b0, pin_oe}, 8'h00);
      rd("R3 data", 3'd1, 8'h00);
      rd("R3 pull", 3'd3, 8'h00);
      rd("R3 odrn", 3'd4, 8'h00);

      wr(3'd0, 8'hCF);
      rd("R1 dir read", 3'd0, 8'hFF);
      wr(3'd1, 8'hEA);
      wr(3'd3, 8'h3F);
      #1 chk("R2 oe", {2'b0, pin_oe}, 8'h0F);
      chk("R2 out", {2'b0, pin_out & pin_oe}, 8'h0A);
      rd("R12 data hi bits", 3'd1, 8'h2A);
      rd("R12 pins", 3'd2, 8'h15);
      rd("R12 code5", 3'd5, 8'h00);
      wr(3'd2, 8'hFF);
      wr(3'd6, 8'hFF);
      rd("R12 ro data", 3'd1, 8'h2A);
      rd("R12 ro pull", 3'd3, 8'h3F);
      rd("R12 ro odrn", 3'd4, 8'h00);

      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         mode = VEC[k].mode; addr_en = VEC[k].aen; addr_out = VEC[k].addr;
         #1;
         chk($sformatf("R6/R7 vec%0d oe", k), {2'b0, pin_oe}, {2'b0, VEC[k].oe});
         chk($sformatf("R6/R7 vec%0d out", k), {2'b0, pin_out & pin_oe}, {2'b0, VEC[k].out});
         chk($sformatf("R10 vec%0d pu", k), {2'b0, pin_pu}, {2'b0, VEC[k].pu});
      end

      // R11 open drain; mode 4 aen 1 claims bit 5 only
      wr(3'd4, 8'h2F);
      #1 chk("R11 oe", {2'b0, pin_oe}, 8'h25);
      chk("R11 od", {2'b0, pin_od}, 8'h0F);
      wr(3'd4, 8'h00);

      // R5 software standby with no claim
      @(negedge clk);
      mode = 3'd2; sw_stby = 1'b1;
      repeat (2) @(negedge clk);
      #1 chk("R5 oe", {2'b0, pin_oe}, 8'h0F);
      sw_stby = 1'b0;

      // R8 / R9 standby on claimed pins
      @(negedge clk);
      mode = 3'd6; addr_en = 4'd6; addr_out = 6'h2D;
      @(negedge clk);
      sw_stby = 1'b1; oe_stby = 1'b1; addr_out = 6'h12;
      #1 chk("R8 out", {2'b0, pin_out}, 8'h2D);
      chk("R8 oe", {2'b0, pin_oe}, 8'h3F);
      @(negedge clk);
      #1 chk("R8 out later", {2'b0, pin_out}, 8'h2D);
      oe_stby = 1'b0;
      #1 chk("R9 oe", {2'b0, pin_oe}, 8'h00);
      @(negedge clk);
      sw_stby = 1'b0;
      #1 chk("R6 after stby", {2'b0, pin_out}, 8'h12);

      // R4 hw standby colliding with a direction write
      @(negedge clk);
      mode = 3'd2;
      hw_stby = 1'b1; wr_en = 1'b1; sel = 3'd0; wdata = 8'h3F;
      @(negedge clk);
      hw_stby = 1'b0; wr_en = 1'b0;
      #1 chk("R4 oe", {2'b0, pin_oe}, 8'h00);
      rd("R4 pull kept", 3'd3, 8'h3F);
      rd("R4 data kept", 3'd1, 8'h2A);
      #1 chk("R10 input pulls", {2'b0, pin_pu}, 8'h3F);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule